// File: doc/BRIEF.md
# Four-Key Flash Write-Protection Gate

This block sits between a CPU bus slave port and a small flash array model. It keeps program and erase access shut until software proves it knows four 32-bit protection keys held as ordinary data at the top of the first 8 KB flash sector. Each key is proven with a two-step exchange. First the CPU does a normal read of the key's flash address, which copies the stored word into a hidden compare register. Then the CPU writes its own copy of that key to a key-entry register, and the block compares the two.

A 4-bit match vector records which key indices have matched. When all four bits are set, the gate opens. It raises `wr_enable` and bit 15 of its status word. Any wrong or unprompted key entry clears all progress and closes the gate. While the gate is closed, key words read back as zero, so the keys cannot be discovered through the bus. Program and erase attempts are refused and flagged with an error pulse.

An unlock state machine has four states:
- `S_LOCK_IDLE`: closed, nothing latched.
- `S_LOCK_ARMED`: closed, key latched.
- `S_OPEN_IDLE`: open, nothing latched.
- `S_OPEN_ARMED`: open, key latched.

Its transitions are:
- **load**: a key read. It moves an IDLE state to the matching ARMED state, or re-latches in an ARMED state.
- **match**: a correct entry while ARMED. It goes to `S_OPEN_IDLE` when the vector becomes full or the gate was already open, and to `S_LOCK_IDLE` otherwise.
- **mismatch**: a wrong entry, or any entry from an IDLE state. It goes to `S_LOCK_IDLE` and clears the vector.

Top module: `flash_key_guard`

## Requirements
- R1: The four keys are the flash words at byte addresses 0x1FF0, 0x1FF4, 0x1FF8 and 0x1FFC, which are key indices 0 to 3 (index = address bits 3:2). Data words are modelled at byte addresses 0 to 4*DATA_WORDS-1. Other flash addresses below 0x2000 read as all ones.
- R2: A read of a key address latches that stored key and its index, replacing any earlier latch. Reads of other addresses leave the latch and the match vector unchanged.
- R3: A write to the key-entry register (CTRL_BASE+0x10C) that equals the latched key sets that index's bit in the match vector and consumes the latch. Matching an index that is already set changes nothing.
- R4: A key-entry write that differs from the latched key, or that arrives with no key latched, clears all four match bits and drops the unlock flag.
- R5: The status word is read at CTRL_BASE+0x108. Bit 15 is the unlock flag, bits 3:0 are the match vector, and all other bits are 0. `wr_enable` and bit 15 go high right after the write that completes the fourth match.
- R6: Once open, the block stays open until a mismatching key entry or a reset. This holds even after the stored keys are reprogrammed or erased.
- R7: Every read returns its data with `bus_rvalid` high in the cycle after the request. A key read returns 0 while locked and the stored key while unlocked.
- R8: Reads of non-key flash addresses return the stored data whether locked or unlocked.
- R9: A flash program (a write to a flash address) or an erase (a write to CTRL_BASE+0x110) takes effect only while unlocked. While locked, the array is unchanged and `prot_err` is high for the cycle after the request.
- R10: Reset clears the match vector, the latch and the unlock flag, and loads the array model erased (all ones). All-ones user keys then unlock the block.
- R11: An erase while unlocked sets every data and key word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| wr_enable | output | 1 | Unlock flag: program and erase allowed |
| prot_err | output | 1 | One-cycle pulse for a refused program or erase |

## Verification
The hardest state to reach is an open gate whose stored keys no longer match the keys that opened it. Reaching it needs a full unlock, a reprogramming of all four key words, and then a deliberate mismatch to close the gate. The bench checks both sides of that point. Before the mismatch the gate stays open and the new keys read back in clear. After it the old keys no longer work and the new ones do. Every ordering of the four keys is swept, and so is a mismatch at every step position, so that partial vectors and their clearing are observed through the status word.

// File: rtl/fkg_pkg.sv
package fkg_pkg;
    localparam int KEY_COUNT   = 4;
    localparam int KEY_IDX_W   = 2;
    localparam int SECT_WIDX_W = 11;   // word index inside an 8 KB sector

    typedef enum logic [1:0] {
        S_LOCK_IDLE,
        S_LOCK_ARMED,
        S_OPEN_IDLE,
        S_OPEN_ARMED
    } guard_state_t;

    typedef struct packed {
        logic                   rd;
        logic                   key_rd;
        logic                   key_wr;
        logic                   key_hit;
        logic                   data_hit;
        logic                   flash_rd;
        logic                   stat_rd;
        logic                   prog;
        logic                   erase;
        logic [KEY_IDX_W-1:0]   key_idx;
        logic [SECT_WIDX_W-1:0] data_idx;
    } bus_dec_t;
endpackage

// File: rtl/fkg_decode.sv
module fkg_decode
    import fkg_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_WORDS = 8,
    parameter logic [ADDR_W-1:0] CTRL_BASE  = 16'h8000
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_dec_t          dec
);
    localparam logic [11:0] OFF_STATUS = 12'h108;
    localparam logic [11:0] OFF_KEY    = 12'h10C;
    localparam logic [11:0] OFF_ERASE  = 12'h110;

    logic        flash_hit;
    logic        ctrl_hit;
    logic        rd_req;
    logic        wr_req;
    logic [11:0] offset;

    always_comb begin
        flash_hit = (bus_addr[ADDR_W-1:13] == '0);
        ctrl_hit  = (bus_addr[ADDR_W-1:12] == CTRL_BASE[ADDR_W-1:12]);
        offset    = bus_addr[11:0];
        rd_req    = bus_valid && !bus_write;
        wr_req    = bus_valid && bus_write;

        dec          = '0;
        dec.rd       = rd_req;
        dec.key_hit  = flash_hit && (bus_addr[12:4] == 9'h1FF);
        dec.key_idx  = bus_addr[3:2];
        dec.data_idx = bus_addr[12:2];
        dec.data_hit = flash_hit && (int'(bus_addr[12:2]) < DATA_WORDS);
        dec.flash_rd = rd_req && flash_hit;
        dec.key_rd   = rd_req && dec.key_hit;
        dec.prog     = wr_req && flash_hit;
        dec.stat_rd  = rd_req && ctrl_hit && (offset == OFF_STATUS);
        dec.key_wr   = wr_req && ctrl_hit && (offset == OFF_KEY);
        dec.erase    = wr_req && ctrl_hit && (offset == OFF_ERASE);
    end
endmodule

// File: rtl/fkg_array.sv
module fkg_array
    import fkg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DATA_WORDS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   erase_en,
    input  logic                   key_hit,
    input  logic                   data_hit,
    input  logic [KEY_IDX_W-1:0]   key_idx,
    input  logic [SECT_WIDX_W-1:0] data_idx,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rd_word
);
    localparam int WIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;

    logic [DATA_W-1:0] data_q [DATA_WORDS];
    logic [DATA_W-1:0] key_q  [KEY_COUNT];

    for (genvar g = 0; g < DATA_WORDS; g++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[g] <= '1;
            else if (erase_en)
                data_q[g] <= '1;
            else if (wr_en && data_hit && (data_idx == SECT_WIDX_W'(g)))
                data_q[g] <= wdata;
        end
    end

    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                key_q[k] <= '1;
            else if (erase_en)
                key_q[k] <= '1;
            else if (wr_en && key_hit && (key_idx == KEY_IDX_W'(k)))
                key_q[k] <= wdata;
        end
    end

    always_comb begin
        if (key_hit)
            rd_word = key_q[key_idx];
        else if (data_hit)
            rd_word = data_q[data_idx[WIDX_W-1:0]];
        else
            rd_word = '1;
    end
endmodule

// File: rtl/fkg_unlock_fsm.sv
module fkg_unlock_fsm
    import fkg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 key_rd,
    input  logic                 key_wr,
    input  logic [KEY_IDX_W-1:0] key_idx,
    input  logic [DATA_W-1:0]    stored_word,
    input  logic [DATA_W-1:0]    user_key,
    output logic                 unlocked,
    output logic [KEY_COUNT-1:0] match_vec
);
    guard_state_t         state_q, state_d;
    logic [DATA_W-1:0]    latch_q;
    logic [KEY_IDX_W-1:0] latch_idx_q;
    logic [KEY_COUNT-1:0] vec_q;
    logic [KEY_COUNT-1:0] vec_after;
    logic                 key_ok;
    logic                 do_latch;
    logic                 do_set;
    logic                 do_clear;

    assign key_ok    = (user_key == latch_q);
    assign vec_after = vec_q | (KEY_COUNT'(1) << latch_idx_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LOCK_IDLE;
        else        state_q <= state_d;
    end

    // transitions and the actions they fire
    always_comb begin
        state_d  = state_q;
        do_latch = 1'b0;
        do_set   = 1'b0;
        do_clear = 1'b0;
        unique case (state_q)
            S_LOCK_IDLE: begin
                if (key_rd) begin
                    do_latch = 1'b1;
                    state_d  = S_LOCK_ARMED;
                end else if (key_wr) begin
                    do_clear = 1'b1;
                end
            end
            S_LOCK_ARMED: begin
                if (key_rd) begin
                    do_latch = 1'b1;
                end else if (key_wr) begin
                    if (key_ok) begin
                        do_set  = 1'b1;
                        state_d = (&vec_after) ? S_OPEN_IDLE : S_LOCK_IDLE;
                    end else begin
                        do_clear = 1'b1;
                        state_d  = S_LOCK_IDLE;
                    end
                end
            end
            S_OPEN_IDLE: begin
                if (key_rd) begin
                    do_latch = 1'b1;
                    state_d  = S_OPEN_ARMED;
                end else if (key_wr) begin
                    do_clear = 1'b1;
                    state_d  = S_LOCK_IDLE;
                end
            end
            S_OPEN_ARMED: begin
                if (key_rd) begin
                    do_latch = 1'b1;
                end else if (key_wr) begin
                    if (key_ok) begin
                        do_set  = 1'b1;
                        state_d = S_OPEN_IDLE;
                    end else begin
                        do_clear = 1'b1;
                        state_d  = S_LOCK_IDLE;
                    end
                end
            end
            default: state_d = S_LOCK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q     <= '0;
            latch_idx_q <= '0;
            vec_q       <= '0;
        end else begin
            if (do_latch) begin
                latch_q     <= stored_word;
                latch_idx_q <= key_idx;
            end
            if (do_clear)
                vec_q <= '0;
            else if (do_set)
                vec_q <= vec_after;
        end
    end

    // outputs
    always_comb begin
        unlocked  = (state_q == S_OPEN_IDLE) || (state_q == S_OPEN_ARMED);
        match_vec = vec_q;
    end
endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard
    import fkg_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 32,
    parameter int                DATA_WORDS = 8,
    parameter logic [ADDR_W-1:0] CTRL_BASE  = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              wr_enable,
    output logic              prot_err
);
    localparam int UNLOCK_BIT = 15;

    bus_dec_t             dec;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    rd_next;
    logic [DATA_W-1:0]    status_word;
    logic [KEY_COUNT-1:0] match_vec;
    logic                 unlocked;

    fkg_decode #(
        .ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS), .CTRL_BASE(CTRL_BASE)
    ) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .dec(dec)
    );

    fkg_array #(
        .DATA_W(DATA_W), .DATA_WORDS(DATA_WORDS)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dec.prog && unlocked),
        .erase_en(dec.erase && unlocked),
        .key_hit(dec.key_hit), .data_hit(dec.data_hit),
        .key_idx(dec.key_idx), .data_idx(dec.data_idx),
        .wdata(bus_wdata), .rd_word(rd_word)
    );

    fkg_unlock_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .key_rd(dec.key_rd), .key_wr(dec.key_wr), .key_idx(dec.key_idx),
        .stored_word(rd_word), .user_key(bus_wdata),
        .unlocked(unlocked), .match_vec(match_vec)
    );

    always_comb begin
        status_word                 = '0;
        status_word[UNLOCK_BIT]     = unlocked;
        status_word[KEY_COUNT-1:0]  = match_vec;
        if (dec.stat_rd)
            rd_next = status_word;
        else if (dec.flash_rd && dec.key_hit)
            rd_next = unlocked ? rd_word : '0;
        else if (dec.flash_rd)
            rd_next = rd_word;
        else
            rd_next = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            prot_err   <= 1'b0;
        end else begin
            bus_rvalid <= dec.rd;
            if (dec.rd)
                bus_rdata <= rd_next;
            prot_err <= (dec.prog || dec.erase) && !unlocked;
        end
    end

    assign wr_enable = unlocked;
endmodule

// File: rtl/flash_key_guard_chk.sv
module flash_key_guard_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              wr_enable,
    input logic              prot_err
);
    localparam logic [ADDR_W-1:0] KEY_ENTRY = CTRL_BASE + ADDR_W'('h10C);
    localparam logic [ADDR_W-1:0] ERASE_REG = CTRL_BASE + ADDR_W'('h110);

    logic key_write, key_read, any_read, guarded_write;
    assign key_write     = bus_valid && bus_write && (bus_addr == KEY_ENTRY);
    assign key_read      = bus_valid && !bus_write && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'('h1FF));
    assign any_read      = bus_valid && !bus_write;
    assign guarded_write = bus_valid && bus_write &&
                           ((bus_addr[ADDR_W-1:13] == '0) || (bus_addr == ERASE_REG));

    p_open_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_enable) |-> $past(key_write));

    p_close_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_enable) |-> $past(key_write));

    p_key_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_read && !wr_enable) |=> (bus_rvalid && bus_rdata == '0));

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_read |=> bus_rvalid);

    p_err_only_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> $past(guarded_write && !wr_enable));

    p_no_err_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded_write && wr_enable) |=> !prot_err);
endmodule

bind flash_key_guard flash_key_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_BASE(CTRL_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .wr_enable(wr_enable), .prot_err(prot_err)
);

// File: tb/sim_flash_key_guard.sv
module sim_flash_key_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int DW         = 32;
    localparam int NDATA      = 8;
    localparam logic [15:0] A_STATUS = 16'h8108;
    localparam logic [15:0] A_KEY    = 16'h810C;
    localparam logic [15:0] A_ERASE  = 16'h8110;
    localparam logic [15:0] A_KEY0   = 16'h1FF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          wr_enable;
    logic          prot_err;

    flash_key_guard u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .wr_enable(wr_enable), .prot_err(prot_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    logic [DW-1:0] mkey [4];
    logic [DW-1:0] mdata [NDATA];
    logic [3:0]    mvec;
    logic          munl;
    logic          mlat_v;
    logic [1:0]    mlat_idx;
    logic [DW-1:0] mlat_val;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        chk("R7 rvalid", {31'b0, bus_rvalid}, 32'd1);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v, output logic err);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        err = prot_err;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) mkey[i] = '1;
        for (int i = 0; i < NDATA; i++) mdata[i] = '1;
        mvec = '0; munl = 1'b0; mlat_v = 1'b0; mlat_idx = '0; mlat_val = '0;
    endtask

    task automatic check_status(input string req);
        logic [DW-1:0] d;
        rd(A_STATUS, d);
        chk(req, d, (DW'(munl) << 15) | DW'(mvec));
        chk(req, {31'b0, wr_enable}, DW'(munl));
    endtask

    task automatic key_load(input int i);
        logic [DW-1:0] d;
        rd(A_KEY0 + AW'(4 * i), d);
        chk("R7 key read", d, munl ? mkey[i] : '0);
        mlat_v = 1'b1; mlat_idx = 2'(i); mlat_val = mkey[i];
    endtask

    task automatic key_enter(input logic [DW-1:0] v);
        logic e;
        wr(A_KEY, v, e);
        if (mlat_v && v == mlat_val) begin
            mvec = mvec | (4'b1 << mlat_idx);
            if (mvec == 4'hF) munl = 1'b1;
        end else begin
            mvec = '0; munl = 1'b0;
        end
        mlat_v = 1'b0;
        chk("R5 flag after entry", {31'b0, wr_enable}, DW'(munl));
    endtask

    task automatic unlock_all();
        for (int i = 0; i < 4; i++) begin
            key_load(i);
            key_enter(mkey[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic e;
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 wr_enable at reset", {31'b0, wr_enable}, 32'd0);
        chk("R10 prot_err at reset", {31'b0, prot_err}, 32'd0);
        chk("R10 rvalid at reset", {31'b0, bus_rvalid}, 32'd0);
        rst_n = 1'b1;
        check_status("R10 status after reset");

        // R1 / R7: locked key reads come back zero
        for (int i = 0; i < 4; i++) key_load(i);
        check_status("R2 latch alone leaves vector");

        // R3 / R5: every ordering of the four keys
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    int ord [4];
                    if (a == b || a == c || b == c) continue;
                    ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = 6 - a - b - c;
                    for (int s = 0; s < 4; s++) begin
                        key_load(ord[s]);
                        key_enter(mkey[ord[s]]);
                        check_status("R5 status during ordering");
                    end
                    chk("R5 open after four", {31'b0, wr_enable}, 32'd1);
                    key_enter(32'h0);   // R4: no latch -> mismatch
                    check_status("R4 relock by unprompted entry");
                end

        // R4: a mismatch at each step position
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < p; s++) begin
                key_load(s);
                key_enter(mkey[s]);
            end
            key_load(p);
            key_enter(mkey[p] ^ (DW'(1) << (p * 8 + 3)));
            check_status("R4 mismatch clears vector");
        end

        // R3: repeat match of one index
        key_load(0); key_enter(mkey[0]);
        key_load(0); key_enter(mkey[0]);
        check_status("R3 repeat match no change");
        key_enter(mkey[0]);
        check_status("R4 entry with no latch");

        // R2: non-key reads between load and entry
        key_load(1);
        rd(16'h0004, d);
        chk("R8 data read locked", d, mdata[1]);
        rd(A_STATUS, d);
        key_enter(mkey[1]);
        check_status("R2 latch survives other reads");
        key_enter(32'h0);

        // R9: locked program and erase refused
        wr(16'h000C, 32'h1234_5678, e);
        chk("R9 program err locked", {31'b0, e}, 32'd1);
        rd(16'h000C, d);
        chk("R9 array unchanged", d, mdata[3]);
        wr(A_ERASE, 32'h0, e);
        chk("R9 erase err locked", {31'b0, e}, 32'd1);
        wr(A_KEY0, 32'h0, e);
        chk("R9 key program err locked", {31'b0, e}, 32'd1);

        // R8: program data while open
        unlock_all();
        for (int i = 0; i < NDATA; i++) begin
            mdata[i] = 32'h5A5A_0000 + DW'(i) * 32'h111;
            wr(AW'(4 * i), mdata[i], e);
            chk("R9 program no err open", {31'b0, e}, 32'd0);
        end
        for (int i = 0; i < NDATA; i++) begin
            rd(AW'(4 * i), d);
            chk("R8 data read open", d, mdata[i]);
        end
        rd(16'h0100, d);
        chk("R1 unmodelled flash reads ones", d, '1);

        // R6: reprogram keys, gate stays open
        for (int i = 0; i < 4; i++) begin
            mkey[i] = 32'hC0DE_0000 + DW'(i) * 32'h0707;
            wr(A_KEY0 + AW'(4 * i), mkey[i], e);
        end
        check_status("R6 open after key reprogram");
        for (int i = 0; i < 4; i++) key_load(i);   // R7 clear key reads
        key_enter(32'h0);
        check_status("R6 relock by mismatch");
        for (int i = 0; i < 4; i++) key_load(i);   // R7 masked again
        for (int i = 0; i < NDATA; i++) begin
            rd(AW'(4 * i), d);
            chk("R8 data read after relock", d, mdata[i]);
        end
        key_load(0); key_enter('1);
        check_status("R4 old keys rejected");
        unlock_all();
        check_status("R5 new keys open");

        // R11: erase while open
        wr(A_ERASE, 32'h0, e);
        chk("R11 erase no err", {31'b0, e}, 32'd0);
        for (int i = 0; i < NDATA; i++) mdata[i] = '1;
        for (int i = 0; i < 4; i++) mkey[i] = '1;
        rd(16'h0008, d);
        chk("R11 data erased", d, '1);
        for (int i = 0; i < 4; i++) key_load(i);
        check_status("R6 open after erase");

        // R10: reset locks and erases, ones reopen
        wr(16'h0008, 32'h77, e);
        do_reset();
        check_status("R10 status after second reset");
        rd(16'h0008, d);
        chk("R10 array erased by reset", d, '1);
        unlock_all();
        check_status("R10 all-ones keys open");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule